// File: doc/BRIEF.md
# GPIO Port Data Register Block

This block holds the data side of a 32-pin general-purpose I/O port behind a small memory-mapped register interface. Software sees six 32-bit words. One is an output latch that can be written whole. Three are write-only mask ports that set, clear or invert selected latch bits in one access, so there is no read-modify-write race. One is a direction word, and one is a read-only image of the pin levels after synchronization.

The pad side gets one output value, one output enable and one input line per pin. The bus is a single valid/write/address/data port. A read request returns its data, from a register, in the cycle after the request. The address is a byte address, and bits [1:0] are ignored. Pin multiplexing, pulls, drive strength, filtering and interrupts belong to other blocks.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output latch and the direction word are all zero: `pad_out` is 0, `pad_oe` is 0 and both words read back as 0.
- R2: A write to offset 0x00 loads the output latch with the write data, and a read of 0x00 returns the latch.
- R3: A write to offset 0x04 forces to 1 every latch bit whose data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 forces to 0 every latch bit whose data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts every latch bit whose data bit is 1 and leaves the other bits unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C return 0.
- R7: Offset 0x14 is a read/write direction word. Bit n = 1 makes pin n an output, and `pad_oe` equals the word.
- R8: `pad_out` always presents the output latch, whatever the direction word holds.
- R9: Offset 0x10 returns `pad_in` through a two-flop synchronizer. A level applied to `pad_in` just after a clock edge shows up in the third read issued from that point on, counting back-to-back reads. Writes to 0x10 change nothing.
- R10: Read data appears on `bus_rdata` in the cycle after the read request. In every other cycle `bus_rdata` is 0.
- R11: Offsets 0x18 and above read as 0, and writes to them change nothing. A cycle without `bus_valid` changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |

## Verification
A mask write to the set, clear or toggle port can land in the same cycle as a pin edge moving through the input synchronizer. The bench changes `pad_in` and issues latch writes and input reads back to back. It then judges `pad_out` against a software model of the latch and the read values against the fixed two-stage latency. Two mask writes can also follow one another directly, for example a set followed at once by a toggle of overlapping bits. This checks that each operation acts on the result of the previous one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_SET  = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_TOG  = 3'd3,
        SEL_PINS = 3'd4,
        SEL_DIR  = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    always_comb begin
        word = addr[ADDR_W-1:2];
        case (word)
            WORD_W'(0): sel = SEL_DATA;
            WORD_W'(1): sel = SEL_SET;
            WORD_W'(2): sel = SEL_CLR;
            WORD_W'(3): sel = SEL_TOG;
            WORD_W'(4): sel = SEL_PINS;
            WORD_W'(5): sel = SEL_DIR;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pins_sync
);
    logic [NPINS-1:0] stage_d [STAGES];
    logic [NPINS-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = pad_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign pins_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] latch,
    output logic [NPINS-1:0] dir
);
    typedef struct packed {
        logic [NPINS-1:0] latch;
        logic [NPINS-1:0] dir;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_DATA: st_d.latch = wr_data;
                SEL_SET:  st_d.latch = st_q.latch | wr_data;
                SEL_CLR:  st_d.latch = st_q.latch & ~wr_data;
                SEL_TOG:  st_d.latch = st_q.latch ^ wr_data;
                SEL_DIR:  st_d.dir   = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch = st_q.latch;
    assign dir   = st_q.dir;

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SET) |=>
            ((latch & $past(wr_data)) == $past(wr_data)) &&
            ((latch & ~$past(wr_data)) == ($past(latch) & ~$past(wr_data))));

    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CLR) |=>
            ((latch & $past(wr_data)) == '0) &&
            ((latch & ~$past(wr_data)) == ($past(latch) & ~$past(wr_data))));

    p_tog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_TOG) |=> (latch == ($past(latch) ^ $past(wr_data))));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel == SEL_NONE || wr_sel == SEL_PINS) |=> ($stable(latch) && $stable(dir)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    reg_sel_e         sel;
    logic [NPINS-1:0] latch, dir, pins_sync;
    logic [NPINS-1:0] rdata_d, rdata_q;
    logic             wr_en, rd_en;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    gpio_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_out_regs #(.NPINS(NPINS)) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (bus_wdata),
        .latch   (latch),
        .dir     (dir)
    );

    gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_in    (pad_in),
        .pins_sync (pins_sync)
    );

    always_comb begin
        rdata_d = '0;
        if (rd_en) begin
            case (sel)
                SEL_DATA: rdata_d = latch;
                SEL_PINS: rdata_d = pins_sync;
                SEL_DIR:  rdata_d = dir;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
    assign pad_out   = latch;
    assign pad_oe    = dir;

    p_wo_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == SEL_SET || sel == SEL_CLR || sel == SEL_TOG)) |=> (bus_rdata == '0));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (bus_rdata == '0));

    p_data_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_DATA) |=> (bus_rdata == $past(pad_out)));

    p_dir_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_DIR) |=> (bus_rdata == $past(pad_oe)));
endmodule

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a negedge; returns just after the next negedge
    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        check("R1 pad_out", pad_out, '0);
        check("R1 pad_oe", pad_oe, '0);
        bus_rd(8'h00, r); check("R1 data", r, '0);
        bus_rd(8'h14, r); check("R1 dir", r, '0);
    endtask

    task automatic t_data;
        logic [31:0] r;
        bus_wr(8'h00, 32'hA5C3_0F91); model = 32'hA5C3_0F91;
        check("R8 pad_out", pad_out, model);
        bus_rd(8'h00, r); check("R2 readback", r, model);
        bus_rd(8'h02, r); check("R2 low addr bits ignored", r, model);
    endtask

    task automatic t_masks;
        logic [31:0] r;
        bus_wr(8'h04, 32'h0000_F00F); model |= 32'h0000_F00F;
        check("R3 set", pad_out, model);
        bus_wr(8'h08, 32'hA000_0011); model &= ~32'hA000_0011;
        check("R4 clear", pad_out, model);
        bus_wr(8'h0C, 32'hFFFF_0000); model ^= 32'hFFFF_0000;
        check("R5 toggle", pad_out, model);
        bus_wr(8'h04, 32'h0101_0101); model |= 32'h0101_0101;
        bus_wr(8'h0C, 32'h0303_0303); model ^= 32'h0303_0303;
        check("R5 set then toggle", pad_out, model);
        bus_rd(8'h04, r); check("R6 set reads 0", r, '0);
        bus_rd(8'h08, r); check("R6 clear reads 0", r, '0);
        bus_rd(8'h0C, r); check("R6 toggle reads 0", r, '0);
    endtask

    task automatic t_dir;
        logic [31:0] r;
        bus_wr(8'h14, 32'h00FF_00F0);
        check("R7 pad_oe", pad_oe, 32'h00FF_00F0);
        bus_rd(8'h14, r); check("R7 readback", r, 32'h00FF_00F0);
        check("R8 pad_out independent of dir", pad_out, model);
    endtask

    task automatic t_input;
        logic [31:0] r1, r2, r3;
        pad_in = 32'h1234_5678;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        bus_rd(8'h10, r1); check("R9 settled", r1, 32'h1234_5678);
        pad_in = 32'hCAFE_0001;
        bus_rd(8'h10, r1);
        bus_rd(8'h10, r2);
        bus_rd(8'h10, r3);
        check("R9 first read old", r1, 32'h1234_5678);
        check("R9 second read old", r2, 32'h1234_5678);
        check("R9 third read new", r3, 32'hCAFE_0001);
        bus_wr(8'h10, 32'h0);
        bus_rd(8'h10, r1); check("R9 write ignored", r1, 32'hCAFE_0001);
        check("R9 write no latch effect", pad_out, model);
    endtask

    task automatic t_unmapped;
        logic [31:0] r;
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_wr(8'hFC, 32'hFFFF_FFFF);
        check("R11 latch untouched", pad_out, model);
        check("R11 dir untouched", pad_oe, 32'h00FF_00F0);
        bus_rd(8'h18, r); check("R11 read zero", r, '0);
        bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0;
        @(negedge clk);
        bus_write = 1'b0;
        check("R11 no valid no write", pad_out, model);
        bus_rd(8'h00, r); check("R10 read data", r, model);
        @(negedge clk);
        check("R10 idle zero", bus_rdata, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data();
        t_masks();
        t_dir();
        t_input();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule